// File: doc/BRIEF.md
# Pixel Region Latency Buffer

This block serves a square group of sixteen pixels in a hybrid pixel readout array. It watches the sixteen discriminator outputs, measures a time-over-threshold (TOT) value for each pixel in bunch-clock periods, and groups all pixels that fire in the same bunch crossing into one region event. Each event takes one entry of a small pool that the whole region shares. An entry holds one bunch-crossing tag and sixteen 4-bit TOT fields.

In triggered mode, entries wait for a trigger that arrives a programmable number of crossings after the hit. An entry whose tag equals the current crossing minus the latency is flagged for readout. An entry that nobody claims is released once it is older than the latency. In trigger-less mode, every finished entry goes out as soon as it is complete. Records leave through a valid/ready port toward a column bus. Each record carries the region address, the crossing tag and the sixteen TOT fields. A hit that finds the pool full is lost, and a saturating drop counter counts it.

Top module: `pxr_latbuf`

## Requirements
- R1: A pixel's 4-bit TOT field equals the number of consecutive bunch-clock samples in which its discriminator is high, counted from the sample where it rises and clamped at 15. A pixel that did not fire in the event reads 0. Pixel p occupies bits [4p+3:4p] of `rec_tot_o`.
- R2: All pixels that rise in the same cycle share one entry, tagged with the `bid_i` value of that cycle. A rise in a later cycle opens a separate entry.
- R3: In triggered mode (`trigless_i`=0), a `trig_i` pulse sampled with crossing B flags every entry whose tag equals (B − `latency_i`) mod 1024. Only flagged entries are sent out.
- R4: In triggered mode, an unflagged entry is released once its age (`bid_i` − tag, mod 1024) exceeds `latency_i`. Its slot can then be reused without any drop.
- R5: A cycle in which at least one pixel rises while no entry is free drops those hits. It adds one to `drop_cnt_o`, which saturates at its all-ones value. Dropped hits never appear in a record.
- R6: In trigger-less mode (`trigless_i`=1), every complete entry is sent without a trigger, and `trig_i` has no effect.
- R7: Among entries that are ready to send, the earliest allocated one is presented first.
- R8: While `rec_valid_o` is high and `rec_ready_i` is low, the record is held unchanged. An entry is released only by the handshake, so a stalled port keeps its slot occupied.
- R9: Every record carries `region_id_i` in `rec_region_o`.
- R10: After reset, no record is valid and `drop_cnt_o` is 0.
- R11: A pixel that stays high after its measurement ends starts no new measurement until its discriminator has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disc_i | input | 16 | Discriminator output for each pixel |
| bid_i | input | 10 | Bunch-crossing counter |
| trig_i | input | 1 | Trigger strobe |
| latency_i | input | 10 | Trigger latency in crossings |
| trigless_i | input | 1 | 1 selects trigger-less mode |
| region_id_i | input | 14 | Region address placed in records |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_region_o | output | 14 | Region address of the record |
| rec_bid_o | output | 10 | Crossing tag of the record |
| rec_tot_o | output | 64 | Sixteen 4-bit TOT fields |
| drop_cnt_o | output | 8 | Saturating count of dropped hit cycles |

## Verification
The assertions assume that `bid_i` advances by one every clock. They also assume that `trigless_i` and `latency_i` stay constant between resets, and that the latency is at least 16 crossings, so that every entry is complete before its trigger can match it. The stimulus drives the crossing counter from a free-running cycle count. It changes mode and latency only while reset is held, and it uses latencies of 40 and 500. Random events space their pixel pulses so that each one ends low within 21 cycles.

// File: rtl/pxr_latbuf.sv
module pxr_latbuf #(
  parameter int NPIX   = 16,
  parameter int TOT_W  = 4,
  parameter int BID_W  = 10,
  parameter int NENT   = 4,
  parameter int ADDR_W = 14,
  parameter int OVF_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NPIX-1:0]         disc_i,
  input  logic [BID_W-1:0]        bid_i,
  input  logic                    trig_i,
  input  logic [BID_W-1:0]        latency_i,
  input  logic                    trigless_i,
  input  logic [ADDR_W-1:0]       region_id_i,
  output logic                    rec_valid_o,
  input  logic                    rec_ready_i,
  output logic [ADDR_W-1:0]       rec_region_o,
  output logic [BID_W-1:0]        rec_bid_o,
  output logic [NPIX*TOT_W-1:0]   rec_tot_o,
  output logic [OVF_W-1:0]        drop_cnt_o
);
  localparam int EI_W = (NENT > 1) ? $clog2(NENT) : 1;
  localparam logic [TOT_W-1:0] TOT_MAX = '1;

  logic [NPIX-1:0]  disc_q, busy;
  logic [EI_W-1:0]  pix_ent [NPIX];
  logic [NENT-1:0]  e_vld, e_flag;
  logic [BID_W-1:0] e_bid [NENT];
  logic [TOT_W-1:0] e_tot [NENT][NPIX];
  logic [NPIX-1:0]  e_pend [NENT];
  logic [NENT-1:0]  older [NENT];
  logic             lock;
  logic [EI_W-1:0]  lock_idx;
  logic [OVF_W-1:0] drops;

  logic [NPIX-1:0]  rise;
  logic             any_rise, alloc_ok, alloc_go, sel_ok, fire;
  logic [EI_W-1:0]  alloc_idx, sel_idx, cur_idx;
  logic [NENT-1:0]  expire, sendable;
  logic [BID_W-1:0] match_bid;

  assign rise      = disc_i & ~disc_q & ~busy;
  assign any_rise  = |rise;
  assign alloc_go  = any_rise & alloc_ok;
  assign match_bid = bid_i - latency_i;

  always_comb begin
    alloc_ok  = 1'b0;
    alloc_idx = '0;
    for (int e = NENT-1; e >= 0; e--)
      if (!e_vld[e]) begin
        alloc_ok  = 1'b1;
        alloc_idx = EI_W'(e);
      end
  end

  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      expire[e]   = e_vld[e] && !e_flag[e] && !trigless_i &&
                    ((bid_i - e_bid[e]) > latency_i);
      sendable[e] = e_vld[e] && (e_pend[e] == '0) && (e_flag[e] || trigless_i);
    end
  end

  always_comb begin : pick_oldest
    logic blocked;
    sel_ok  = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < NENT; i++) begin
      blocked = 1'b0;
      for (int j = 0; j < NENT; j++)
        if (sendable[j] && older[j][i]) blocked = 1'b1;
      if (sendable[i] && !blocked) begin
        sel_ok  = 1'b1;
        sel_idx = EI_W'(i);
      end
    end
  end

  assign cur_idx      = lock ? lock_idx : sel_idx;
  assign rec_valid_o  = lock | sel_ok;
  assign fire         = rec_valid_o & rec_ready_i;
  assign rec_region_o = region_id_i;
  assign rec_bid_o    = e_bid[cur_idx];
  assign drop_cnt_o   = drops;

  for (genvar p = 0; p < NPIX; p++) begin : g_out
    assign rec_tot_o[p*TOT_W +: TOT_W] = e_tot[cur_idx][p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disc_q <= '0;
      busy   <= '0;
      for (int p = 0; p < NPIX; p++) pix_ent[p] <= '0;
    end else begin
      disc_q <= disc_i;
      for (int p = 0; p < NPIX; p++) begin
        if (busy[p]) begin
          if (!disc_i[p] || e_tot[pix_ent[p]][p] == TOT_MAX) busy[p] <= 1'b0;
        end else if (rise[p] && alloc_ok) begin
          busy[p]    <= 1'b1;
          pix_ent[p] <= alloc_idx;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_vld  <= '0;
      e_flag <= '0;
      for (int e = 0; e < NENT; e++) begin
        e_bid[e]  <= '0;
        e_pend[e] <= '0;
        older[e]  <= '0;
        for (int p = 0; p < NPIX; p++) e_tot[e][p] <= '0;
      end
    end else begin
      for (int e = 0; e < NENT; e++) begin
        if (fire && cur_idx == EI_W'(e)) begin
          e_vld[e]  <= 1'b0;
          e_flag[e] <= 1'b0;
        end else if (expire[e]) begin
          e_vld[e] <= 1'b0;
        end else if (alloc_go && alloc_idx == EI_W'(e)) begin
          e_vld[e]  <= 1'b1;
          e_flag[e] <= 1'b0;
          e_bid[e]  <= bid_i;
          e_pend[e] <= rise;
          for (int p = 0; p < NPIX; p++)
            e_tot[e][p] <= rise[p] ? TOT_W'(1) : '0;
        end else begin
          if (trig_i && !trigless_i && e_vld[e] && e_bid[e] == match_bid)
            e_flag[e] <= 1'b1;
          for (int p = 0; p < NPIX; p++)
            if (busy[p] && pix_ent[p] == EI_W'(e)) begin
              if (disc_i[p] && e_tot[e][p] != TOT_MAX)
                e_tot[e][p] <= e_tot[e][p] + 1'b1;
              else
                e_pend[e][p] <= 1'b0;
            end
        end
        if (alloc_go && alloc_idx == EI_W'(e))
          older[e] <= '0;
        else if (alloc_go)
          older[e][alloc_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock     <= 1'b0;
      lock_idx <= '0;
      drops    <= '0;
    end else begin
      if (fire) lock <= 1'b0;
      else if (rec_valid_o && !lock) begin
        lock     <= 1'b1;
        lock_idx <= sel_idx;
      end
      if (any_rise && !alloc_ok && drops != '1) drops <= drops + 1'b1;
    end
  end
endmodule

// File: rtl/pxr_latbuf_chk.sv
module pxr_latbuf_chk #(
  parameter int NPIX  = 16,
  parameter int TOT_W = 4,
  parameter int BID_W = 10,
  parameter int OVF_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rec_valid_o,
  input logic                  rec_ready_i,
  input logic [BID_W-1:0]      rec_bid_o,
  input logic [NPIX*TOT_W-1:0] rec_tot_o,
  input logic [OVF_W-1:0]      drop_cnt_o
);
  // R8
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o);

  // R8
  rec_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> $stable(rec_bid_o) && $stable(rec_tot_o));

  // R1
  rec_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> rec_tot_o != '0);

  // R5
  drop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_cnt_o != $past(drop_cnt_o) |-> drop_cnt_o == $past(drop_cnt_o) + 1'b1);
endmodule

bind pxr_latbuf pxr_latbuf_chk #(
  .NPIX(NPIX), .TOT_W(TOT_W), .BID_W(BID_W), .OVF_W(OVF_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rec_valid_o(rec_valid_o),
  .rec_ready_i(rec_ready_i), .rec_bid_o(rec_bid_o), .rec_tot_o(rec_tot_o),
  .drop_cnt_o(drop_cnt_o)
);

// File: tb/pxr_latbuf_tb_top.sv
module pxr_latbuf_tb_top;
  localparam int OW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, trig, trigless, rdy_man, rnd_mode, rnd_bit;
  logic [15:0] disc;
  logic [9:0]  lat;
  logic [13:0] rid;
  logic [31:0] cyc = 0;
  logic        ready, v;
  logic [13:0] r_reg;
  logic [9:0]  r_bid;
  logic [63:0] r_tot;
  logic [OW-1:0] drops;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) rnd_bit <= ($urandom_range(3) != 0);
  assign ready = rnd_mode ? rnd_bit : rdy_man;

  pxr_latbuf #(.OVF_W(OW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .disc_i(disc), .bid_i(cyc[9:0]),
    .trig_i(trig), .latency_i(lat), .trigless_i(trigless),
    .region_id_i(rid), .rec_valid_o(v), .rec_ready_i(ready),
    .rec_region_o(r_reg), .rec_bid_o(r_bid), .rec_tot_o(r_tot),
    .drop_cnt_o(drops));

  int nchk = 0, nerr = 0, nrec = 0;
  logic [9:0]  m_bid [128];
  logic [63:0] m_tot [128];
  logic [13:0] m_reg [128];

  always @(negedge clk) begin
    #1;
    if (rst_n && v && ready) begin
      m_bid[nrec % 128] = r_bid;
      m_tot[nrec % 128] = r_tot;
      m_reg[nrec % 128] = r_reg;
      nrec++;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int st [16];
  int wd [16];

  task automatic clear_pat();
    for (int p = 0; p < 16; p++) begin st[p] = 0; wd[p] = 0; end
  endtask

  function automatic logic [63:0] exp_tot(int off);
    logic [63:0] r = '0;
    for (int p = 0; p < 16; p++)
      if (wd[p] > 0 && st[p] == off) r[p*4 +: 4] = (wd[p] > 15) ? 4'd15 : 4'(wd[p]);
    return r;
  endfunction

  task automatic run_pat(int len, output logic [31:0] c0);
    c0 = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 0) c0 = cyc;
      for (int p = 0; p < 16; p++)
        disc[p] = (wd[p] > 0) && (k >= st[p]) && (k < st[p] + wd[p]);
    end
    @(negedge clk);
    disc = '0;
  endtask

  task automatic pulse_at(logic [31:0] c);
    while (cyc < c) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic do_reset(logic mode, logic [9:0] l);
    rst_n = 1'b0; disc = '0; trig = 1'b0; rdy_man = 1'b1; rnd_mode = 1'b0;
    trigless = mode; lat = l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  logic [31:0] c0, c1;
  int base;
  logic [9:0]  e_bid [40];
  logic [63:0] e_tot [40];
  logic [9:0]  h_bid;
  logic [63:0] h_tot;

  initial begin
    void'($urandom(32'd20240611));
    rid = 14'h2A5C;
    do_reset(1'b1, 10'd40);
    // R10
    chk("R10", "valid after reset", 64'(v), 64'd0);
    chk("R10", "drops after reset", 64'(drops), 64'd0);

    // R1 R2 R9 R6: one grouped event in trigger-less mode
    clear_pat(); wd[0] = 1; wd[5] = 7; wd[15] = 20; wd[9] = 15;
    base = nrec;
    run_pat(22, c0);
    pulse_at(c0 + 40);
    repeat (10) @(negedge clk);
    chk("R2", "records for one crossing", 64'(nrec - base), 64'd1);
    chk("R2", "tag", 64'(m_bid[base % 128]), 64'(c0[9:0]));
    chk("R1", "tot fields", m_tot[base % 128], exp_tot(0));
    chk("R9", "region", 64'(m_reg[base % 128]), 64'(rid));
    chk("R6", "trigger adds nothing", 64'(nrec - base), 64'd1);

    // R2 R11: rises one cycle apart, and a long pulse
    clear_pat(); st[2] = 0; wd[2] = 2; st[3] = 1; wd[3] = 3; st[6] = 3; wd[6] = 40;
    base = nrec;
    run_pat(45, c0);
    repeat (10) @(negedge clk);
    chk("R2", "separate entries", 64'(nrec - base), 64'd3);
    chk("R2", "second tag", 64'(m_bid[(base + 1) % 128]), 64'(c0[9:0] + 10'd1));
    chk("R1", "second tot", m_tot[(base + 1) % 128], exp_tot(1));
    chk("R11", "saturated long pulse", m_tot[(base + 2) % 128], exp_tot(3));

    // R7: three ready entries sent in allocation order
    rdy_man = 1'b0;
    clear_pat(); st[1] = 0; wd[1] = 3; st[2] = 2; wd[2] = 1; st[3] = 4; wd[3] = 2;
    base = nrec;
    run_pat(8, c0);
    repeat (20) @(negedge clk);
    rdy_man = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7", "count", 64'(nrec - base), 64'd3);
    chk("R7", "first", 64'(m_bid[base % 128]), 64'(c0[9:0]));
    chk("R7", "second", 64'(m_bid[(base + 1) % 128]), 64'(c0[9:0] + 10'd2));
    chk("R7", "third", 64'(m_bid[(base + 2) % 128]), 64'(c0[9:0] + 10'd4));
    chk("R7", "third tot", m_tot[(base + 2) % 128], exp_tot(4));

    // R8: stalled port holds the record and its slot
    do_reset(1'b1, 10'd40);
    rdy_man = 1'b0;
    clear_pat(); wd[7] = 5;
    base = nrec;
    run_pat(6, c0);
    repeat (12) @(negedge clk);
    h_bid = r_bid; h_tot = r_tot;
    chk("R8", "valid while stalled", 64'(v), 64'd1);
    for (int k = 0; k < 8; k++) @(negedge clk);
    chk("R8", "held tag", 64'(r_bid), 64'(h_bid));
    chk("R8", "held tot", r_tot, h_tot);
    clear_pat(); st[8] = 0; wd[8] = 1; st[9] = 2; wd[9] = 1; st[10] = 4; wd[10] = 1;
    run_pat(6, c1);
    clear_pat(); wd[11] = 1;
    run_pat(2, c1);
    chk("R8", "slot kept until handshake", 64'(drops), 64'd1);
    rdy_man = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8", "records after release", 64'(nrec - base), 64'd4);
    chk("R8", "first released", 64'(m_bid[base % 128]), 64'(c0[9:0]));

    // R3 R4: triggered mode, expiry frees slots
    do_reset(1'b0, 10'd40);
    clear_pat(); st[0] = 0; wd[0] = 1; st[1] = 2; wd[1] = 1; st[2] = 4; wd[2] = 1; st[3] = 6; wd[3] = 1;
    base = nrec;
    run_pat(8, c0);
    repeat (60) @(negedge clk);
    chk("R3", "no trigger no record", 64'(nrec - base), 64'd0);
    clear_pat(); st[4] = 0; wd[4] = 1; st[5] = 2; wd[5] = 1; st[6] = 4; wd[6] = 1; st[7] = 6; wd[7] = 1;
    run_pat(8, c1);
    chk("R4", "expired slots reused", 64'(drops), 64'd0);
    pulse_at(c1 + 46);
    repeat (5) @(negedge clk);
    chk("R3", "one match", 64'(nrec - base), 64'd1);
    chk("R3", "matched tag", 64'(m_bid[base % 128]), 64'(c1[9:0] + 10'd6));
    chk("R3", "matched tot", m_tot[base % 128], exp_tot(6));

    // R5: full pool drops and saturates
    do_reset(1'b0, 10'd500);
    clear_pat(); st[0] = 0; wd[0] = 1; st[1] = 2; wd[1] = 1; st[2] = 4; wd[2] = 1; st[3] = 6; wd[3] = 1;
    base = nrec;
    run_pat(8, c0);
    clear_pat(); wd[8] = 1;
    run_pat(2, c1);
    chk("R5", "one drop", 64'(drops), 64'd1);
    clear_pat();
    for (int p = 8; p < 16; p++) begin st[p] = 2 * (p - 8); wd[p] = 1; end
    run_pat(17, c1);
    clear_pat(); wd[8] = 1;
    run_pat(2, c1);
    chk("R5", "saturated", 64'(drops), 64'(2**OW - 1));
    pulse_at(c0 + 500);
    repeat (5) @(negedge clk);
    chk("R5", "kept entry read", 64'(nrec - base), 64'd1);
    chk("R5", "kept tag", 64'(m_bid[base % 128]), 64'(c0[9:0]));
    pulse_at(c1 + 500);
    repeat (5) @(negedge clk);
    chk("R5", "dropped hit absent", 64'(nrec - base), 64'd1);

    // R1 R2 R6: random grouped events, random back-pressure
    do_reset(1'b1, 10'd40);
    rnd_mode = 1'b1;
    base = nrec;
    for (int n = 0; n < 30; n++) begin
      clear_pat();
      for (int p = 0; p < 16; p++)
        if ($urandom_range(2) == 0) wd[p] = 1 + $urandom_range(19);
      if (exp_tot(0) == '0) wd[n % 16] = 1 + n % 18;
      e_tot[n] = exp_tot(0);
      run_pat(21, c0);
      e_bid[n] = c0[9:0];
      if ((n % 5) == 0) begin trig = 1'b1; @(negedge clk); trig = 1'b0; end
      repeat (4) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk("R6", "random record count", 64'(nrec - base), 64'd30);
    for (int n = 0; n < 30; n++) begin
      chk("R2", "random tag", 64'(m_bid[(base + n) % 128]), 64'(e_bid[n]));
      chk("R1", "random tot", m_tot[(base + n) % 128], e_tot[n]);
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule